// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block paces the refresh traffic of an SDRAM controller. A 2-bit rate code picks one of three refresh periods, or switches refresh off altogether. A static 2-bit frequency code tells the block which of three core clock rates it runs at. The core clock and the memory bus clock are the same clock. From these two codes the block derives the number of clock cycles in one period. When a period ends, the block raises a single-cycle tick.

Each tick adds one to a small count of refreshes still owed. The command scheduler sees a request level whenever that count is nonzero. The scheduler answers with a single-cycle acknowledge for each refresh it has issued, and every acknowledge takes one off the count. The count is bounded. A tick that arrives while the count is already full raises a saturation flag instead.

Top module: `refresh_timer`

## Requirements
- R1: With the rate code at 00, no tick is produced. On the clock edge where 00 is taken, the pending count and the saturation flag are cleared.
- R2: Rate code 01 gives a period of 7.8 us. With frequency codes 00, 01 and 10 this is 514, 780 and 1037 cycles (floor of 7.8 x MHz).
- R3: Rate code 10 gives a period of 15.6 us. With frequency codes 00, 01 and 10 this is 1029, 1560 and 2074 cycles.
- R4: Rate code 11 gives a period of 125 us. With frequency codes 00, 01 and 10 this is 8250, 12500 and 16625 cycles.
- R5: The frequency code selects the clock rate: 00 is 66 MHz, 01 is 100 MHz, and both 10 and 11 are 133 MHz.
- R6: A change of rate code restarts the period on the edge that samples it. The first tick of the new rate comes exactly one full new period later. The pending count is not altered by a change to a nonzero code. Ticks are single-cycle pulses.
- R7: A tick raises the pending count by one, up to a limit of 8. An acknowledge lowers the count by one. An acknowledge while the count is 0 has no effect. A tick and an acknowledge in the same cycle leave the count unchanged.
- R8: A tick that arrives while the count is 8 and no acknowledge is present leaves the count at 8 and sets the saturation flag. The flag stays set until code 00 is selected.
- R9: The refresh request output is high exactly when the pending count is nonzero.
- R10: After reset the block behaves as rate code 00 with the pending count at 0. The request, tick and saturation outputs are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock (same as the memory bus clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 2 | Static clock-rate code (00 = 66, 01 = 100, 1x = 133 MHz) |
| rate_sel | input | 2 | Refresh rate code (00 = off, 01 = 7.8 us, 10 = 15.6 us, 11 = 125 us) |
| refresh_ack | input | 1 | Single-cycle pulse: one refresh has been issued |
| refresh_tick | output | 1 | Single-cycle pulse at the end of each period |
| refresh_req | output | 1 | High while refreshes are pending |
| pending_cnt | output | 4 | Number of refreshes still owed |
| pending_sat | output | 1 | Sticky flag: a period ended with the count full |

## Verification
The assertions check the following on every cycle:
- No tick is ever produced while the code is off.
- The off code clears the count and the flag.
- The count stays within its bound.
- The count moves by exactly one on a lone tick or a lone acknowledge.
- A tick into a full count sets the saturation flag.
- A tick never lasts two cycles.

The exact period length for each of the twelve rate and frequency pairings can only be shown by the bench scenarios, which measure the gap between ticks. The same holds for the restart on a rate change, the retention of the count across that change, and the stickiness of the flag after later acknowledges.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;

   typedef enum logic [1:0] {
      RATE_OFF  = 2'b00,
      RATE_FAST = 2'b01,
      RATE_MID  = 2'b10,
      RATE_SLOW = 2'b11
   } rate_e;

   // period in tenths of a microsecond times clock in MHz, floored
   function automatic int unsigned interval_cycles(int unsigned tenth_us,
                                                   int unsigned mhz);
      return (tenth_us * mhz) / 10;
   endfunction

endpackage

// File: rtl/refresh_interval_ctr.sv
module refresh_interval_ctr
   import refresh_timer_pkg::*;
#(
   parameter int unsigned T_FAST = 78,
   parameter int unsigned T_MID  = 156,
   parameter int unsigned T_SLOW = 1250,
   parameter int unsigned F_LO   = 66,
   parameter int unsigned F_MID  = 100,
   parameter int unsigned F_HI   = 133
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] freq_sel,
   input  logic [1:0] rate_sel,
   output logic       tick,
   output logic       clear
);

   localparam int unsigned MAX_CYC = interval_cycles(T_SLOW, F_HI);
   localparam int unsigned MIN_CYC = interval_cycles(T_FAST, F_LO);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC);

   if (!(T_FAST < T_MID && T_MID < T_SLOW)) begin : g_bad_periods
      $error("refresh periods must be strictly increasing");
   end
   if (!(F_LO < F_MID && F_MID < F_HI)) begin : g_bad_freqs
      $error("clock rates must be strictly increasing");
   end
   if (MIN_CYC < 2) begin : g_bad_min
      $error("shortest period must be at least two cycles");
   end

   function automatic int unsigned tenths_of(int unsigned r);
      return (r == 1) ? T_FAST : (r == 2) ? T_MID : T_SLOW;
   endfunction

   function automatic int unsigned mhz_of(int unsigned f);
      return (f == 0) ? F_LO : (f == 1) ? F_MID : F_HI;
   endfunction

   logic [CNT_W-1:0] reload_tbl [4][4];

   for (genvar f = 0; f < 4; f++) begin : g_freq
      for (genvar r = 0; r < 4; r++) begin : g_rate
         localparam int unsigned CYC =
            (r == 0) ? 1 : interval_cycles(tenths_of(r), mhz_of(f));
         assign reload_tbl[f][r] = CNT_W'(CYC - 1);
      end
   end

   rate_e            rate_q;
   logic [CNT_W-1:0] cnt_q;
   logic             changed;
   logic [1:0]       idx;
   logic [CNT_W-1:0] load_val;

   assign changed  = (rate_sel != rate_q);
   assign idx      = changed ? rate_sel : rate_q;
   assign load_val = reload_tbl[freq_sel][idx];
   assign tick     = (rate_q != RATE_OFF) && !changed && (cnt_q == '0);
   assign clear    = changed && (rate_sel == RATE_OFF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= RATE_OFF;
         cnt_q  <= '0;
      end else if (changed) begin
         rate_q <= rate_e'(rate_sel);
         cnt_q  <= load_val;
      end else if (rate_q != RATE_OFF) begin
         cnt_q  <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/refresh_pending_ctr.sv
module refresh_pending_ctr #(
   parameter int unsigned PEND_MAX   = 8,
   parameter bit          SAT_STICKY = 1'b1,
   localparam int unsigned PW        = $clog2(PEND_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          ack,
   input  logic          clear,
   output logic [PW-1:0] count,
   output logic          sat
);

   if (PEND_MAX < 1) begin : g_bad_depth
      $error("pending limit must be at least one");
   end

   localparam logic [PW-1:0] MAX_V = PW'(PEND_MAX);

   logic [PW-1:0] count_q;
   logic          take;
   logic          over;

   assign take = ack && (count_q != '0);
   assign over = tick && !take && (count_q == MAX_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (clear) begin
         count_q <= '0;
      end else if (tick && !take) begin
         if (count_q != MAX_V) count_q <= count_q + 1'b1;
      end else if (!tick && take) begin
         count_q <= count_q - 1'b1;
      end
   end

   if (SAT_STICKY) begin : g_sticky
      logic sat_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clear) sat_q <= 1'b0;
         else if (over)       sat_q <= 1'b1;
      end
      assign sat = sat_q;
   end else begin : g_pulse
      logic sat_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clear) sat_q <= 1'b0;
         else                 sat_q <= over;
      end
      assign sat = sat_q;
   end

   assign count = count_q;

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
   parameter int unsigned PEND_MAX = 8,
   localparam int unsigned PW      = $clog2(PEND_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    freq_sel,
   input  logic [1:0]    rate_sel,
   input  logic          refresh_ack,
   output logic          refresh_tick,
   output logic          refresh_req,
   output logic [PW-1:0] pending_cnt,
   output logic          pending_sat
);

   logic tick;
   logic clear;

   refresh_interval_ctr u_interval (
      .clk      (clk),
      .rst_n    (rst_n),
      .freq_sel (freq_sel),
      .rate_sel (rate_sel),
      .tick     (tick),
      .clear    (clear)
   );

   refresh_pending_ctr #(
      .PEND_MAX   (PEND_MAX),
      .SAT_STICKY (1'b1)
   ) u_pending (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .ack   (refresh_ack),
      .clear (clear),
      .count (pending_cnt),
      .sat   (pending_sat)
   );

   assign refresh_tick = tick;
   assign refresh_req  = (pending_cnt != '0);

endmodule

// File: rtl/refresh_timer_chk.sv
module refresh_timer_chk #(
   parameter int unsigned PEND_MAX = 8,
   localparam int unsigned PW      = $clog2(PEND_MAX + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    rate_sel,
   input logic          refresh_ack,
   input logic          refresh_tick,
   input logic [PW-1:0] pending_cnt,
   input logic          pending_sat
);

   localparam logic [PW-1:0] MAX_V = PW'(PEND_MAX);

   a_r1_off_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == 2'b00) |-> !refresh_tick);

   a_r1_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == 2'b00) |=> (pending_cnt == '0 && !pending_sat));

   a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_tick |=> !refresh_tick);

   a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pending_cnt <= MAX_V);

   a_r7_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_tick && !refresh_ack && pending_cnt != MAX_V)
      |=> (pending_cnt == $past(pending_cnt) + 1'b1));

   a_r7_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_ack && !refresh_tick && pending_cnt != '0 && rate_sel != 2'b00)
      |=> (pending_cnt == $past(pending_cnt) - 1'b1));

   a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_tick && !refresh_ack && pending_cnt == MAX_V)
      |=> (pending_sat && pending_cnt == MAX_V));

endmodule

bind refresh_timer refresh_timer_chk #(.PEND_MAX(PEND_MAX)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rate_sel     (rate_sel),
   .refresh_ack  (refresh_ack),
   .refresh_tick (refresh_tick),
   .pending_cnt  (pending_cnt),
   .pending_sat  (pending_sat)
);

// File: tb/refresh_timer_tb.sv
module refresh_timer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int PMAX       = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] freq_sel = 2'b00;
   logic [1:0] rate_sel = 2'b00;
   logic       refresh_ack = 1'b0;
   logic       refresh_tick;
   logic       refresh_req;
   logic [3:0] pending_cnt;
   logic       pending_sat;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   refresh_timer u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .freq_sel     (freq_sel),
      .rate_sel     (rate_sel),
      .refresh_ack  (refresh_ack),
      .refresh_tick (refresh_tick),
      .refresh_req  (refresh_req),
      .pending_cnt  (pending_cnt),
      .pending_sat  (pending_sat)
   );

   function automatic int exp_cycles(int f, int r);
      int t;
      int m;
      t = (r == 1) ? 78 : (r == 2) ? 156 : 1250;
      m = (f == 0) ? 66 : (f == 1) ? 100 : 133;
      return (t * m) / 10;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic go_off();
      @(negedge clk) rate_sel = 2'b00;
      @(negedge clk);
   endtask

   // counts negedges until a tick is seen
   task automatic wait_tick(output int n, input int limit);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!refresh_tick && n < limit);
   endtask

   task automatic measure(int f, int r, int reps, string tag);
      int n;
      go_off();
      freq_sel = 2'(f);
      rate_sel = 2'(r);
      for (int k = 0; k < reps; k++) begin
         wait_tick(n, 20000);
         chk(tag, n, exp_cycles(f, r));
      end
   endtask

   task automatic pulse_ack();
      refresh_ack = 1'b1;
      @(negedge clk);
      refresh_ack = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      int ticks;
      int m;
      bit msat;
      int seed;
      seed = $urandom(32'd20240611);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 pending", pending_cnt, 0);
      chk("R10 req", refresh_req, 0);
      chk("R10 sat", pending_sat, 0);
      chk("R10 tick", refresh_tick, 0);

      // R1: disabled code produces nothing
      ticks = 0;
      freq_sel = 2'b01;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (refresh_tick) ticks++;
      end
      chk("R1 ticks while off", ticks, 0);
      chk("R1 pending while off", pending_cnt, 0);

      // R2 R3 R5: periods at each clock rate
      for (int f = 0; f < 3; f++) begin
         measure(f, 1, 2, "R2/R5 period 7.8us");
         measure(f, 2, 2, "R3/R5 period 15.6us");
      end
      measure(3, 1, 2, "R5 code 11 is 133MHz");
      // R4
      for (int f = 0; f < 3; f++) measure(f, 3, 1, "R4 period 125us");

      // R8 and R9: saturation
      go_off();
      freq_sel = 2'b00;
      rate_sel = 2'b01;
      for (int k = 0; k < 8; k++) wait_tick(n, 20000);
      @(negedge clk);
      chk("R7 count after 8 ticks", pending_cnt, 8);
      chk("R8 no sat at 8", pending_sat, 0);
      chk("R9 req with pending", refresh_req, 1);
      wait_tick(n, 20000);
      @(negedge clk);
      chk("R8 count held", pending_cnt, 8);
      chk("R8 sat set", pending_sat, 1);
      pulse_ack();
      chk("R7 ack decrement", pending_cnt, 7);
      chk("R8 sat sticky", pending_sat, 1);

      // R6: rate change restarts period and keeps count
      repeat (100) @(negedge clk);
      rate_sel = 2'b10;
      @(negedge clk);
      chk("R6 count kept", pending_cnt, 7);
      n = 1;
      while (!refresh_tick && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk("R6 restart period", n, exp_cycles(0, 2));
      @(negedge clk);
      chk("R6 tick after change", pending_cnt, 8);

      // R1: off code clears
      rate_sel = 2'b00;
      @(negedge clk);
      chk("R1 clear count", pending_cnt, 0);
      chk("R1 clear sat", pending_sat, 0);
      chk("R9 req low", refresh_req, 0);

      // R7: ack at zero ignored, rate running
      freq_sel = 2'b01;
      rate_sel = 2'b01;
      @(negedge clk);
      pulse_ack();
      chk("R7 ack at zero", pending_cnt, 0);

      // R7 R8 R9: random acknowledges against a model
      go_off();
      rate_sel = 2'b01;
      m = 0;
      msat = 1'b0;
      for (int i = 1; i <= 9000; i++) begin
         bit et;
         bit a;
         @(negedge clk);
         et = ((i % 780) == 0);
         chk("R6 random tick", refresh_tick, et);
         chk("R7 random count", pending_cnt, m);
         chk("R9 random req", refresh_req, (m != 0));
         chk("R8 random sat", pending_sat, msat);
         if (et) a = ($urandom % 2) == 1;
         else if (i < 4500) a = ($urandom % 3000) == 0;
         else a = ($urandom % 150) == 0;
         refresh_ack = a;
         if (et && !(a && m > 0)) begin
            if (m == PMAX) msat = 1'b1;
            else m++;
         end else if (!et && a && m > 0) begin
            m--;
         end
      end
      refresh_ack = 1'b0;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule